// File: doc/BRIEF.md
# Area-Timed External Bus Cycle Sequencer

This block turns single CPU access requests into external bus cycles. The top three address bits pick one of eight address areas. A per-area bit decides whether the cycle runs through two numbered states (T1, T2) or three (T1, T2, T3). During the cycle the block drives the address, a read or write strobe, a per-area chip-select and write data. A small window of control registers sits at the top of the address map. It holds the per-area state selection, a bus-width byte, a wait-control byte, the chip-select pin enables, the upper-address pin enables and a bus-release enable.

Register writes follow two timing rules. Writes that shape cycle timing are stored at once, but they are first used by the cycle after the write. Writes that hand a pin between the bus function and generic I/O change the pin's output enable inside the write's own cycle, from T3 onward. When the release enable is set, an external master can take the bus between cycles. The block then floats its outputs and drives an active-low acknowledge until the master withdraws its request.

Top module: `extBusSeq`

## Requirements
- R1: After reset the state output is 0 (idle), every chip-select output is high, the chip-select output enables equal 8'h01, the four upper address enables are 0, the lower address enables are all 1, the strobe enable is 1 and relAckN is 1. Register reads return 8'hFF (offset 10), 8'h00 (11), 8'h00 (12), 8'h01 (13), 8'h00 (14) and 8'h00 (15).
- R2: The area is reqAddr[23:21]. When bit n of the state-select register (offset 10) is 1, a cycle to area n runs states 1 (T1), 2 (T2) and 3 (T3). When the bit is 0, the cycle runs T1 and T2 only. The state returns to idle (0) after every cycle.
- R3: reqReady is high only in the last state of a cycle. For a read, rdData takes the sampled value (busDataIn, or register contents for the window) at the end of that state, so it is visible from the next cycle.
- R4: In an external cycle to area n, csN[n] is low from T1 through the last state and no other chip-select is low. rdN (read) or wrN (write) is low in T2 and T3 only. Accesses with reqAddr[23:8] = 16'hFFFF reach the register window and assert no chip-select or strobe.
- R5: Register offsets (reqAddr[7:0]) are: 10 state select, 11 bus width, 12 wait control, 13 chip-select pin enables (bit n for area n), 14 upper address enables (bit i for address bit 20+i), 15 release enable (bit 0). Written values read back, and unmapped offsets read 0.
- R6: A write to offsets 10 to 12 does not change the cycle carrying it. For example, clearing the bit of area 7 through a three-state write still takes three states, and the next access to area 7 takes two.
- R7: A write to offset 13 changes csOe from T3 of that write. It is unchanged during T1 and T2. In a two-state write it changes from the cycle after T2.
- R8: A write to offset 14 changes addrOe[23:20] with the same timing as R7.
- R9: From idle, when relReq is high and the release enable is 1, the state becomes 4 (released) on the next edge. In that state all address enables, chip-select enables, strobe and data enables are 0 and relAckN is 0, and a pending CPU request waits. The state returns to idle once relReq is low. relReq has no effect while the enable is 0.
- R10: A release request raised during a cycle does not cut it short. The release is granted on the edge after the cycle's idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | CPU request valid, held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Request address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | High in the last state of a cycle |
| rdData | output | 8 | Read data captured at the end of a read |
| busAddr | output | 24 | External address |
| addrOe | output | 24 | Per-bit address output enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| strobeOe | output | 1 | Strobe output enable |
| csN | output | 8 | Per-area chip-select, active low |
| csOe | output | 8 | Per-area chip-select pin enable |
| busDataOut | output | 8 | Write data to the bus |
| busDataOe | output | 1 | Write data enable |
| busDataIn | input | 8 | Read data from the bus |
| relReq | input | 1 | External master bus request |
| relAckN | output | 1 | Bus-release acknowledge, active low |
| busState | output | 3 | 0 idle, 1 T1, 2 T2, 3 T3, 4 released |

## Verification
A request driven at a falling edge enters T1 on the next rising edge. The bench then samples each state at the following falling edges until it sees reqReady. Read data is read one falling edge after the last state, because it is registered at the end of that state. Pin enables are recorded in every state of a register write, so a change due in T3 (third sample) or after a two-state write (the sample after the cycle) is checked in exactly that slot. Release is checked one edge after relReq rises in idle, and for R10 one edge after the idle state that follows the interrupted cycle.

// File: rtl/extBusPkg.sv
package extBusPkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_REL  = 3'd4
  } busState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchReq;
    logic inT1;
    logic inT2;
    logic inT3;
    logic lastState;
    logic released;
  } ctrlStrobe_t;

  localparam logic [7:0] OFS_STATE  = 8'h10;
  localparam logic [7:0] OFS_WIDTH  = 8'h11;
  localparam logic [7:0] OFS_WAIT   = 8'h12;
  localparam logic [7:0] OFS_CSPIN  = 8'h13;
  localparam logic [7:0] OFS_HIADDR = 8'h14;
  localparam logic [7:0] OFS_REL    = 8'h15;

endpackage

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import extBusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        relReq,
  input  logic        releaseEn,
  input  logic        threeStateSel,
  output busState_e   state,
  output ctrlStrobe_t strobe,
  output logic        reqReady
);

  busState_e nextState;
  logic      cyc3;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (relReq && releaseEn) nextState = ST_REL;
        else if (reqValid)       nextState = ST_T1;
      end
      ST_T1:   nextState = ST_T2;
      ST_T2:   nextState = cyc3 ? ST_T3 : ST_IDLE;
      ST_T3:   nextState = ST_IDLE;
      ST_REL:  if (!relReq) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cyc3  <= 1'b1;
    end else begin
      state <= nextState;
      // cycle length frozen at T1 entry
      if (strobe.latchReq) cyc3 <= threeStateSel;
    end
  end

  always_comb begin
    strobe.latchReq  = (state == ST_IDLE) && (nextState == ST_T1);
    strobe.inT1      = (state == ST_T1);
    strobe.inT2      = (state == ST_T2);
    strobe.inT3      = (state == ST_T3);
    strobe.lastState = (state == ST_T3) || ((state == ST_T2) && !cyc3);
    strobe.released  = (state == ST_REL);
  end

  assign reqReady = strobe.lastState;

endmodule

// File: rtl/extBusDatapath.sv
module extBusDatapath
  import extBusPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int AREA_BITS = 3,
  parameter int HI_PINS   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqWrite,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W-1:0]             busDataIn,
  output logic                          threeStateSel,
  output logic                          releaseEn,
  output logic [ADDR_W-1:0]             busAddr,
  output logic [ADDR_W-1:0]             addrOe,
  output logic                          rdN,
  output logic                          wrN,
  output logic                          strobeOe,
  output logic [(1<<AREA_BITS)-1:0]     csN,
  output logic [(1<<AREA_BITS)-1:0]     csOe,
  output logic [DATA_W-1:0]             busDataOut,
  output logic                          busDataOe,
  output logic [DATA_W-1:0]             rdData,
  output logic                          relAckN
);

  localparam int NAREA = 1 << AREA_BITS;
  localparam int LO_PINS = ADDR_W - HI_PINS;

  logic [ADDR_W-1:0]    curAddr;
  logic                 curWrite;
  logic [DATA_W-1:0]    curData;
  logic                 curIsReg;
  logic [AREA_BITS-1:0] curArea;

  logic [NAREA-1:0]     stateSel, widthSel, waitCtl, csPinEn;
  logic [HI_PINS-1:0]   hiAddrEn;
  logic [DATA_W-1:0]    regRd;
  logic                 active, extCycle, dataPhase;

  assign threeStateSel = stateSel[reqAddr[ADDR_W-1 -: AREA_BITS]];
  assign curArea       = curAddr[ADDR_W-1 -: AREA_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
      curData  <= '0;
      curIsReg <= 1'b0;
    end else if (strobe.latchReq) begin
      curAddr  <= reqAddr;
      curWrite <= reqWrite;
      curData  <= reqWdata;
      curIsReg <= &reqAddr[ADDR_W-1:8];
    end
  end

  // register write commits at the end of T2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateSel  <= '1;
      widthSel  <= '0;
      waitCtl   <= '0;
      csPinEn   <= NAREA'(1);
      hiAddrEn  <= '0;
      releaseEn <= 1'b0;
    end else if (strobe.inT2 && curIsReg && curWrite) begin
      case (curAddr[7:0])
        OFS_STATE:  stateSel  <= curData[NAREA-1:0];
        OFS_WIDTH:  widthSel  <= curData[NAREA-1:0];
        OFS_WAIT:   waitCtl   <= curData[NAREA-1:0];
        OFS_CSPIN:  csPinEn   <= curData[NAREA-1:0];
        OFS_HIADDR: hiAddrEn  <= curData[HI_PINS-1:0];
        OFS_REL:    releaseEn <= curData[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (curAddr[7:0])
      OFS_STATE:  regRd = DATA_W'(stateSel);
      OFS_WIDTH:  regRd = DATA_W'(widthSel);
      OFS_WAIT:   regRd = DATA_W'(waitCtl);
      OFS_CSPIN:  regRd = DATA_W'(csPinEn);
      OFS_HIADDR: regRd = DATA_W'(hiAddrEn);
      OFS_REL:    regRd = DATA_W'(releaseEn);
      default:    regRd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                rdData <= '0;
    else if (strobe.lastState && !curWrite)   rdData <= curIsReg ? regRd : busDataIn;
  end

  assign active    = strobe.inT1 || strobe.inT2 || strobe.inT3;
  assign extCycle  = active && !curIsReg;
  assign dataPhase = extCycle && (strobe.inT2 || strobe.inT3);

  assign rdN        = !(dataPhase && !curWrite);
  assign wrN        = !(dataPhase && curWrite);
  assign busDataOe  = dataPhase && curWrite;
  assign busDataOut = curData;
  assign busAddr    = curAddr;
  assign strobeOe   = !strobe.released;
  assign relAckN    = !strobe.released;
  assign csOe       = csPinEn & {NAREA{!strobe.released}};

  for (genvar a = 0; a < NAREA; a++) begin : g_cs
    assign csN[a] = !(extCycle && (curArea == AREA_BITS'(a)));
  end

  for (genvar b = 0; b < ADDR_W; b++) begin : g_aoe
    if (b < LO_PINS) begin : g_lo
      assign addrOe[b] = !strobe.released;
    end else begin : g_hi
      assign addrOe[b] = hiAddrEn[b-LO_PINS] && !strobe.released;
    end
  end

endmodule

// File: rtl/extBusSeq.sv
module extBusSeq
  import extBusPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int AREA_BITS = 3,
  parameter int HI_PINS   = 4,
  localparam int NAREA    = 1 << AREA_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] addrOe,
  output logic              rdN,
  output logic              wrN,
  output logic              strobeOe,
  output logic [NAREA-1:0]  csN,
  output logic [NAREA-1:0]  csOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              relReq,
  output logic              relAckN,
  output logic [2:0]        busState
);

  busState_e   state;
  ctrlStrobe_t strobe;
  logic        threeStateSel;
  logic        releaseEn;

  extBusCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .relReq       (relReq),
    .releaseEn    (releaseEn),
    .threeStateSel(threeStateSel),
    .state        (state),
    .strobe       (strobe),
    .reqReady     (reqReady)
  );

  extBusDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .AREA_BITS(AREA_BITS),
    .HI_PINS  (HI_PINS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqWdata     (reqWdata),
    .busDataIn    (busDataIn),
    .threeStateSel(threeStateSel),
    .releaseEn    (releaseEn),
    .busAddr      (busAddr),
    .addrOe       (addrOe),
    .rdN          (rdN),
    .wrN          (wrN),
    .strobeOe     (strobeOe),
    .csN          (csN),
    .csOe         (csOe),
    .busDataOut   (busDataOut),
    .busDataOe    (busDataOe),
    .rdData       (rdData),
    .relAckN      (relAckN)
  );

  assign busState = state;

endmodule

// File: rtl/extBusSeqChk.sv
module extBusSeqChk #(
  parameter int ADDR_W  = 24,
  parameter int NAREA   = 8,
  parameter int HI_PINS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        busState,
  input logic              reqReady,
  input logic [NAREA-1:0]  csN,
  input logic [NAREA-1:0]  csOe,
  input logic [ADDR_W-1:0] addrOe,
  input logic              strobeOe,
  input logic              busDataOe,
  input logic              relAckN,
  input logic              relReq,
  input logic              releaseEn,
  input logic              rdN,
  input logic              wrN
);

  p_t1_then_t2_r2: assert property (@(posedge clk) disable iff (!rstN)
    busState == 3'd1 |=> busState == 3'd2);

  p_t3_after_t2_r2: assert property (@(posedge clk) disable iff (!rstN)
    busState == 3'd3 |-> $past(busState) == 3'd2);

  p_ready_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (busState == 3'd2 || busState == 3'd3));

  p_cs_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  p_strobe_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> (busState == 3'd2 || busState == 3'd3));

  p_cs_pin_timing_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busState != 3'd4 && $past(busState) != 3'd4 && csOe != $past(csOe))
      |-> $past(busState) == 3'd2);

  p_hi_pin_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busState != 3'd4 && $past(busState) != 3'd4 &&
     addrOe[ADDR_W-1 -: HI_PINS] != $past(addrOe[ADDR_W-1 -: HI_PINS]))
      |-> $past(busState) == 3'd2);

  p_release_hiz_r9: assert property (@(posedge clk) disable iff (!rstN)
    busState == 3'd4 |-> (addrOe == '0 && csOe == '0 && !strobeOe &&
                          !busDataOe && !relAckN));

  p_release_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busState == 3'd0 && relReq && !releaseEn) |=> busState != 3'd4);

  p_no_break_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busState == 3'd1 || busState == 3'd2) |=> busState != 3'd4);

endmodule

bind extBusSeq extBusSeqChk #(
  .ADDR_W (ADDR_W),
  .NAREA  (NAREA),
  .HI_PINS(HI_PINS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busState (busState),
  .reqReady (reqReady),
  .csN      (csN),
  .csOe     (csOe),
  .addrOe   (addrOe),
  .strobeOe (strobeOe),
  .busDataOe(busDataOe),
  .relAckN  (relAckN),
  .relReq   (relReq),
  .releaseEn(releaseEn),
  .rdN      (rdN),
  .wrN      (wrN)
);

// File: tb/tb_extBusSeq.sv
module tb_extBusSeq;

  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] REGB = 24'hFFFF00;

  // {addr 24, write 1, wdata 8, states 3, checkRd 1, rd 8}
  localparam int NVEC = 12;
  localparam logic [44:0] VEC [NVEC] = '{
    {24'h000010, 1'b0, 8'h00, 3'd3, 1'b1, 8'h4A},
    {24'h612345, 1'b0, 8'h00, 3'd3, 1'b1, 8'h1F},
    {24'hFFFF10, 1'b1, 8'hF6, 3'd3, 1'b0, 8'h00},
    {24'h000020, 1'b0, 8'h00, 3'd2, 1'b1, 8'h7A},
    {24'h6000FF, 1'b0, 8'h00, 3'd2, 1'b1, 8'hA5},
    {24'hA00001, 1'b0, 8'h00, 3'd3, 1'b1, 8'h5B},
    {24'hFFFF10, 1'b0, 8'h00, 3'd3, 1'b1, 8'hF6},
    {24'hFFFF10, 1'b1, 8'h76, 3'd3, 1'b0, 8'h00},
    {24'hFFFF10, 1'b0, 8'h00, 3'd2, 1'b1, 8'h76},
    {24'hFFFF10, 1'b1, 8'hFF, 3'd2, 1'b0, 8'h00},
    {24'hFFFF99, 1'b0, 8'h00, 3'd3, 1'b1, 8'h00},
    {24'h400000, 1'b1, 8'h33, 3'd3, 1'b0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        relReq = 1'b0;
  logic        reqReady, rdN, wrN, strobeOe, busDataOe, relAckN;
  logic [7:0]  rdData, busDataOut, busDataIn, csN, csOe;
  logic [23:0] busAddr, addrOe;
  logic [2:0]  busState;

  int nChecks = 0;
  int nFail = 0;

  logic [7:0] csOeAt [4];
  logic [3:0] hiOeAt [4];
  logic [7:0] csOeAfter;
  logic [3:0] hiOeAfter;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign busDataIn = busAddr[7:0] ^ 8'h5A;

  extBusSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdData(rdData), .busAddr(busAddr), .addrOe(addrOe), .rdN(rdN),
    .wrN(wrN), .strobeOe(strobeOe), .csN(csN), .csOe(csOe),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn),
    .relReq(relReq), .relAckN(relAckN), .busState(busState)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input logic [23:0] a, input logic w, input logic [7:0] d,
                          output int n, output logic [7:0] rd, output logic hit,
                          output logic other, output logic strb);
    logic done;
    int   guard;
    n = 0; hit = 0; other = 0; strb = 0; done = 0; guard = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqWdata = d;
    while (!done && guard < 20) begin
      @(negedge clk);
      guard++;
      if (busState != 3'd0) begin
        if (n < 4) begin
          csOeAt[n] = csOe;
          hiOeAt[n] = addrOe[23:20];
        end
        n++;
        if (csN[a[23:21]] == 1'b0) hit = 1;
        if (((~csN) & ~(8'h01 << a[23:21])) != 8'h00) other = 1;
        if (!rdN || !wrN) strb = 1;
        if (reqReady) done = 1;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    rd = rdData;
    csOeAfter = csOe;
    hiOeAfter = addrOe[23:20];
  endtask

  task automatic regWr(input logic [7:0] ofs, input logic [7:0] d, output int n);
    logic [7:0] rd;
    logic h, o, s;
    doAccess(REGB | 24'(ofs), 1'b1, d, n, rd, h, o, s);
  endtask

  task automatic regRd(input logic [7:0] ofs, output logic [7:0] rd);
    int n;
    logic h, o, s;
    doAccess(REGB | 24'(ofs), 1'b0, 8'h00, n, rd, h, o, s);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int         n;
    logic [7:0] rd;
    logic       hit, other, strb;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    check("R1 state", 32'(busState), 32'd0);
    check("R1 csN", 32'(csN), 32'hFF);
    check("R1 csOe", 32'(csOe), 32'h01);
    check("R1 addrOe", 32'(addrOe), 32'h0FFFFF);
    check("R1 strobeOe/relAckN", {30'd0, strobeOe, relAckN}, 32'd3);
    regRd(8'h10, rd); check("R1 reg10", 32'(rd), 32'hFF);
    regRd(8'h11, rd); check("R1 reg11", 32'(rd), 32'h00);
    regRd(8'h12, rd); check("R1 reg12", 32'(rd), 32'h00);
    regRd(8'h13, rd); check("R1 reg13", 32'(rd), 32'h01);
    regRd(8'h14, rd); check("R1 reg14", 32'(rd), 32'h00);
    regRd(8'h15, rd); check("R1 reg15", 32'(rd), 32'h00);

    // vector table: R2 state counts, R6 deferred timing, R3 read data, R4 strobes
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] va;
      logic        ext;
      va  = VEC[i][44:21];
      ext = (va[23:8] != 16'hFFFF);
      doAccess(va, VEC[i][20], VEC[i][19:12], n, rd, hit, other, strb);
      check($sformatf("R2/R6 states vec%0d", i), 32'(n), 32'(VEC[i][11:9]));
      if (VEC[i][8]) check($sformatf("R3/R5 rdData vec%0d", i), 32'(rd), 32'(VEC[i][7:0]));
      check($sformatf("R4 cs/strobe vec%0d", i), {29'd0, hit, strb, other},
            ext ? 32'd6 : 32'd0);
    end

    // R7 chip-select pin enable from T3 of the write
    regWr(8'h13, 8'h03, n);
    check("R7 states", 32'(n), 32'd3);
    check("R7 csOe T1", 32'(csOeAt[0]), 32'h01);
    check("R7 csOe T2", 32'(csOeAt[1]), 32'h01);
    check("R7 csOe T3", 32'(csOeAt[2]), 32'h03);
    regWr(8'h10, 8'h7F, n);
    regWr(8'h13, 8'h07, n);
    check("R7 two-state count", 32'(n), 32'd2);
    check("R7 two-state csOe T2", 32'(csOeAt[1]), 32'h03);
    check("R7 two-state csOe after", 32'(csOeAfter), 32'h07);
    regWr(8'h10, 8'hFF, n);

    // R8 upper address enables
    regWr(8'h14, 8'h05, n);
    check("R8 hiOe T2", 32'(hiOeAt[1]), 32'h0);
    check("R8 hiOe T3", 32'(hiOeAt[2]), 32'h5);

    // R5 readback
    regWr(8'h11, 8'h0A, n);
    regRd(8'h11, rd); check("R5 width", 32'(rd), 32'h0A);
    regWr(8'h12, 8'h3C, n);
    regRd(8'h12, rd); check("R5 wait", 32'(rd), 32'h3C);
    regRd(8'h13, rd); check("R5 cspin", 32'(rd), 32'h07);
    regRd(8'h14, rd); check("R5 hiaddr", 32'(rd), 32'h05);

    // R9 release ignored while disabled
    @(negedge clk); relReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 disabled state", 32'(busState), 32'd0);
    check("R9 disabled ack", 32'(relAckN), 32'd1);
    relReq = 1'b0;
    regWr(8'h15, 8'h01, n);
    @(negedge clk); relReq = 1'b1;
    @(negedge clk);
    check("R9 released state", 32'(busState), 32'd4);
    check("R9 released outputs", {relAckN, strobeOe, csOe, addrOe[21:0]}, 32'd0);
    reqValid = 1'b1; reqAddr = 24'h000040; reqWrite = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 request waits", 32'(busState), 32'd4);
    relReq = 1'b0; reqValid = 1'b0;
    @(negedge clk);
    check("R9 back to idle", {23'd0, relAckN, csOe}, {23'd0, 1'b1, 8'h07});

    // R10 release during a cycle waits for the cycle end
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 24'h000040; reqWrite = 1'b0;
    @(negedge clk);
    check("R10 T1", 32'(busState), 32'd1);
    relReq = 1'b1;
    @(negedge clk);
    check("R10 T2", 32'(busState), 32'd2);
    @(negedge clk);
    check("R10 T3", {28'd0, reqReady, busState}, 32'hB);
    @(negedge clk);
    check("R10 idle", 32'(busState), 32'd0);
    reqValid = 1'b0;
    @(negedge clk);
    check("R10 granted", 32'(busState), 32'd4);
    relReq = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule